// File: doc/BRIEF.md
# Dual-Tone Telephone Keypad Tone Synthesizer

This block turns a 4-bit keypad digit code into a stream of digital samples. Each sample holds one low-group frequency and one high-group frequency of the telephone keypad signalling plan. The block runs from a single fast system clock. A clock enable that pulses at 3.579545 MHz paces it. Two identical channels, one per frequency group, each hold a divider and a 5-bit phase counter.

The divider counts enable pulses up to a terminal count picked by the digit. When it reaches that count, it restarts and advances the phase counter by one step. Every tone period therefore has exactly 32 phase steps. The divider length alone sets the frequency. Each phase addresses a computed 32-point sine table.

The two samples are summed into a signed word, with the high group lifted by about 2 dB as a x5/4 shift-add. A one-group mode outputs either the low or the high group. A mute control forces silence. Downstream logic takes the word whenever the valid strobe is high. That logic holds the converter and filter, which are outside this block.

Top module: `dtmf_synth`

## Requirements
- R1: While `rst_n` is low, and until the first enabled edge after it, `sample_out` is 0 and `sample_vld` is 0.
- R2: The digit code maps to a row and a column of the keypad as follows:
  - Codes 0001 to 1001 are the digits 1 to 9. They fill rows 0 to 2 left to right, in columns 0 to 2.
  - Row 3 holds 1011 (*) in column 0, 1010 (0) in column 1 and 1100 (#) in column 2.
  - Column 3 holds 1101, 1110 and 1111 (A, B, C) in rows 0 to 2, and 0000 (D) in row 3.
- R3: The low-group divider length is 160, 146, 132 or 118 enable pulses for rows 0 to 3. These give 699.1, 766.2, 847.4 and 948.0 Hz.
- R4: The high-group divider length is 92, 84, 76 or 68 enable pulses for columns 0 to 3. These give 1215.9, 1331.7, 1471.9 and 1645.0 Hz.
- R5: A code write (`code_wr` high at an edge) does the following:
  - It latches `code_in`.
  - It clears both dividers and both phase counters.
  - It stops both channels from advancing at that edge.
  - Afterwards, each phase steps once per full divider length, and wraps after 32 steps.
- R6: The sample for phase p is round(127*sin(2*pi*p/32)) as a signed 8-bit value. For example, the samples are 0, 25, 49, 71, 90, 106, 117, 125 and 127 for p = 0 to 8.
- R7: In dual mode (`single_sel`=0) the sum is lo + hi + floor(hi/4).
- R8: In single mode (`single_sel`=1), `col_sel`=1 gives hi + floor(hi/4) and `col_sel`=0 gives lo.
- R9: With `tone_en`=0, every sample is 0, while the counters keep running.
- R10: At each edge with `osc_en` high, `sample_out` loads the sum of the phases held before that edge. `sample_vld` is high exactly in the cycle after each such edge. Otherwise, `sample_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | 3.579545 MHz tone-timebase enable pulse |
| code_wr | input | 1 | Latch `code_in` and restart both phases |
| code_in | input | 4 | Keypad digit code |
| tone_en | input | 1 | 1 = tone output on, 0 = silent samples |
| single_sel | input | 1 | 1 = one group only, 0 = both groups |
| col_sel | input | 1 | In single mode: 1 = high group, 0 = low group |
| sample_out | output | 10 | Signed summed sample |
| sample_vld | output | 1 | High for one cycle after each new sample |

## Verification
The write edge itself only clears state. The first new sample comes one enabled edge later, is visible after it, and shows phase 0 of both tones. After that, every sample reflects the phases from one enabled edge earlier. `sample_vld` is one clock behind `osc_en`. The bench keeps a pulse-accurate model of both dividers. It checks every output cycle half a clock after the edge, and updates its model only after it has computed the expected value for that edge. A run with a gapped enable confirms that the output holds on edges where the enable is low.

// File: rtl/dtmf_synth_pkg.sv
package dtmf_synth_pkg;
  localparam int PH_W   = 5;   // 32 phase steps per period
  localparam int SMP_W  = 8;   // signed sine sample width
  localparam int DIV_W  = 8;   // divider counter width
  localparam int NLINE  = 4;   // tones per group
  localparam int MIX_W  = 10;  // summed output width
  localparam int ROW_BASE = 160, ROW_STEP = 14;
  localparam int COL_BASE = 92,  COL_STEP = 8;

  typedef struct packed {
    logic [1:0] row;
    logic [1:0] col;
  } key_pos_t;

  function automatic key_pos_t key_pos(input logic [3:0] code);
    key_pos_t k;
    logic [3:0] v;
    v = code - 4'd1;
    unique case (code)
      4'h0:    k = '{row: 2'd3, col: 2'd3};
      4'hA:    k = '{row: 2'd3, col: 2'd1};
      4'hB:    k = '{row: 2'd3, col: 2'd0};
      4'hC:    k = '{row: 2'd3, col: 2'd2};
      4'hD, 4'hE, 4'hF: k = '{row: 2'(code - 4'hD), col: 2'd3};
      default: k = '{row: 2'(v / 4'd3), col: 2'(v % 4'd3)};
    endcase
    return k;
  endfunction

  function automatic logic [DIV_W-1:0] seg_len(input bit hi, input int idx);
    return hi ? DIV_W'(COL_BASE - COL_STEP * idx) : DIV_W'(ROW_BASE - ROW_STEP * idx);
  endfunction

  function automatic logic signed [SMP_W-1:0] sine_at(input logic [PH_W-1:0] p);
    logic [PH_W-1:0] q;
    logic signed [SMP_W-1:0] m;
    q = p[PH_W-2] ? (PH_W'(16) - {1'b0, p[PH_W-2:0]}) : {1'b0, p[PH_W-2:0]};
    case (q)
      5'd0: m = 8'sd0;    5'd1: m = 8'sd25;   5'd2: m = 8'sd49;
      5'd3: m = 8'sd71;   5'd4: m = 8'sd90;   5'd5: m = 8'sd106;
      5'd6: m = 8'sd117;  5'd7: m = 8'sd125;  default: m = 8'sd127;
    endcase
    return p[PH_W-1] ? -m : m;
  endfunction

  function automatic logic signed [MIX_W-1:0] widen(input logic signed [SMP_W-1:0] s);
    return {{(MIX_W-SMP_W){s[SMP_W-1]}}, s};
  endfunction

  function automatic logic signed [MIX_W-1:0] pre_emph(input logic signed [MIX_W-1:0] x);
    return x + (x >>> 2);
  endfunction
endpackage

// File: rtl/dtmf_key_decode.sv
module dtmf_key_decode
  import dtmf_synth_pkg::*;
(
  input  logic [3:0]       code,
  output logic [NLINE-1:0] row_oh,
  output logic [NLINE-1:0] col_oh
);
  key_pos_t pos;
  assign pos = key_pos(code);

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    assign row_oh[i] = (pos.row == 2'(i));
    assign col_oh[i] = (pos.col == 2'(i));
  end
endmodule

// File: rtl/dtmf_tone_chan.sv
module dtmf_tone_chan
  import dtmf_synth_pkg::*;
#(
  parameter bit HI_GRP = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    osc_en,
  input  logic                    clr,
  input  logic [NLINE-1:0]        line_oh,
  output logic signed [SMP_W-1:0] sample
);
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] div_cnt;
  logic [PH_W-1:0]  phase;
  logic             seg_end;
  logic             step;

  always_comb begin
    divisor = '0;
    for (int i = 0; i < NLINE; i++)
      if (line_oh[i]) divisor = seg_len(HI_GRP, i);
  end

  assign seg_end = (div_cnt == divisor - DIV_W'(1));
  assign step    = osc_en && !clr && seg_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      phase   <= '0;
    end else if (clr) begin
      div_cnt <= '0;
      phase   <= '0;
    end else if (osc_en) begin
      div_cnt <= seg_end ? '0 : div_cnt + DIV_W'(1);
      if (seg_end) phase <= phase + PH_W'(1);
    end
  end

  assign sample = sine_at(phase);

  // R3 and R4: the divider never passes its terminal count
  a_r3_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < divisor);
  a_r5_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> phase == $past(phase) + PH_W'(1));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == '0) && (div_cnt == '0));
  a_r5_no_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(phase));
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_synth_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    osc_en,
  input  logic                    code_wr,
  input  logic [3:0]              code_in,
  input  logic                    tone_en,
  input  logic                    single_sel,
  input  logic                    col_sel,
  output logic signed [MIX_W-1:0] sample_out,
  output logic                    sample_vld
);
  logic [3:0]              code_q;
  logic [NLINE-1:0]        row_oh, col_oh;
  logic signed [SMP_W-1:0] lo_smp, hi_smp;
  logic signed [MIX_W-1:0] lo_x, hi_x, mix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_wr) code_q <= code_in;
  end

  dtmf_key_decode i_dec (.code(code_q), .row_oh(row_oh), .col_oh(col_oh));

  dtmf_tone_chan #(.HI_GRP(1'b0)) i_lo (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .clr(code_wr),
    .line_oh(row_oh), .sample(lo_smp));

  dtmf_tone_chan #(.HI_GRP(1'b1)) i_hi (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .clr(code_wr),
    .line_oh(col_oh), .sample(hi_smp));

  assign lo_x = widen(lo_smp);
  assign hi_x = pre_emph(widen(hi_smp));

  always_comb begin
    if (!tone_en)       mix = '0;
    else if (single_sel) mix = col_sel ? hi_x : lo_x;
    else                mix = lo_x + hi_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= osc_en;
      if (osc_en) sample_out <= mix;
    end
  end

  a_r2_two_lines: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(row_oh) == 1) && ($countones(col_oh) == 1));
  a_r10_vld_high: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |=> sample_vld);
  a_r10_vld_low: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !sample_vld);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> $stable(sample_out));
  a_r9_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_en && osc_en) |=> sample_out == '0);
  a_r8_single_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && single_sel && !col_sel && osc_en) |=> sample_out == widen($past(lo_smp)));
endmodule

// File: tb/test_dtmf_synth.sv
module test_dtmf_synth;
  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, code_wr = 1'b0;
  logic [3:0] code_in = 4'h0;
  logic tone_en = 1'b1, single_sel = 1'b0, col_sel = 1'b0;
  logic signed [9:0] sample_out;
  logic sample_vld;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  real row_f[4] = '{699.1, 766.2, 847.4, 948.0};
  real col_f[4] = '{1215.9, 1331.7, 1471.9, 1645.0};

  always #10 clk = ~clk;

  dtmf_synth i_dtmf_synth (.clk(clk), .rst_n(rst_n), .osc_en(osc_en), .code_wr(code_wr),
    .code_in(code_in), .tone_en(tone_en), .single_sel(single_sel), .col_sel(col_sel),
    .sample_out(sample_out), .sample_vld(sample_vld));

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // keypad position from the code via character tables
  function automatic void key_rc(input logic [3:0] code, output int r, output int c);
    string by_code = "D1234567890*#ABC";
    string pad     = "123A456B789C*0#D";
    r = 0; c = 0;
    for (int i = 0; i < 16; i++)
      if (pad[i] == by_code[code]) begin r = i / 4; c = i % 4; end
  endfunction

  function automatic int seg_of(real f);
    return $rtoi(3579545.0 / 32.0 / f + 0.5);
  endfunction

  function automatic int sine_ref(int p);
    real x;
    x = 127.0 * $sin(2.0 * 3.14159265358979 * p / 32.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int quarter_floor(int x);
    return (x >= 0) ? x / 4 : -((-x + 3) / 4);
  endfunction

  function automatic int mix_ref(int pr, int pc, bit ten, bit sgl, bit col);
    int lo, hi;
    lo = sine_ref(pr); hi = sine_ref(pc);
    if (!ten) return 0;
    if (sgl) return col ? hi + quarter_floor(hi) : lo;
    return lo + hi + quarter_floor(hi);
  endfunction

  task automatic run_tone(string req, logic [3:0] code, bit ten, bit sgl, bit col, int n, bit gapped);
    int r, c, dr, dc, cr, cc, pr, pc, last, e;
    bit en;
    key_rc(code, r, c);
    dr = seg_of(row_f[r]); dc = seg_of(col_f[c]);
    @(negedge clk);
    code_in = code; code_wr = 1'b1; osc_en = 1'b1;
    tone_en = ten; single_sel = sgl; col_sel = col;
    @(negedge clk);
    code_wr = 1'b0;
    cr = 0; cc = 0; pr = 0; pc = 0; last = 0;
    for (int i = 0; i < n; i++) begin
      en = gapped ? (i % 2 == 0) : 1'b1;
      osc_en = en;
      @(negedge clk);
      if (en) begin
        e = mix_ref(pr, pc, ten, sgl, col);
        last = e;
        cr++; if (cr == dr) begin cr = 0; pr = (pr + 1) % 32; end
        cc++; if (cc == dc) begin cc = 0; pc = (pc + 1) % 32; end
      end else e = last;
      chk(req, int'(sample_out), e);
      chk({req, " R10 vld"}, int'(sample_vld), int'(en));
    end
    osc_en = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 sample in reset", int'(sample_out), 0);
    chk("R1 vld in reset", int'(sample_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sample after release", int'(sample_out), 0);
    chk("R1 vld after release", int'(sample_vld), 0);
  endtask

  task automatic t_dual_full();
    run_tone("R3/R4/R5/R6/R7 digit 1", 4'h1, 1, 0, 0, 5200, 0);
    run_tone("R3/R4/R5/R6/R7 digit D", 4'h0, 1, 0, 0, 3850, 0);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 16; k++)
      run_tone("R2 code sweep", 4'(k), 1, 0, 0, 700, 0);
  endtask

  task automatic t_single();
    run_tone("R8 single low digit 9", 4'h9, 1, 1, 0, 4300, 0);
    run_tone("R8 single high digit 5", 4'h5, 1, 1, 1, 2800, 0);
  endtask

  task automatic t_mute();
    run_tone("R9 muted", 4'h7, 0, 0, 0, 500, 0);
  endtask

  task automatic t_gapped();
    run_tone("R10 gapped enable", 4'hC, 1, 0, 0, 2000, 1);
  endtask

  task automatic t_rewrite();
    run_tone("R5 first write", 4'h3, 1, 0, 0, 400, 0);
    run_tone("R5 restart on rewrite", 4'h3, 1, 0, 0, 400, 0);
  endtask

  initial begin
    t_reset();
    t_dual_full();
    t_sweep();
    t_single();
    t_mute();
    t_gapped();
    t_rewrite();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule